// File: doc/BRIEF.md
# Serial systematic BCH(15,k) encoder

This block turns a bit-serial message into a systematic binary BCH codeword of length 15, one bit per clock. A build-time parameter picks how many bit errors the code corrects: one, two or three. That choice fixes the message length k (11, 7 or 5) and the generator polynomial. The block divides by the generator polynomial in a shift register with feedback, and that register holds the n-k parity bits.

A codeword starts with a one-cycle start strobe that carries the first message bit. For the first k clocks each message bit goes to the output unchanged while the remainder builds up in the register. For the remaining 15-k clocks the register's feedback is switched off and its contents shift out as parity. The bit stream cannot be stalled: the output has a valid flag but no ready input, and the source must give one message bit on every clock of the message phase. A new start can follow in the clock right after the fifteenth input clock, so codewords can run with no gap between them. Bits travel highest-degree coefficient first. Every output bit is registered and appears one clock after its input clock.

Top module: `bch15_enc`

## Requirements
- R1: Each codeword equals m(x)·x^(15-k) plus the remainder of that product divided by g(x). The first k output bits are the message bits in the order they were received (highest degree first), followed by the remainder from its highest-degree coefficient down.
- R2: With T_CORR=1, k=11 and g(x)=x^4+x+1.
- R3: With T_CORR=2 (the default), k=7 and g(x)=x^8+x^7+x^6+x^4+1.
- R4: With T_CORR=3, k=5 and g(x)=x^10+x^8+x^5+x^4+x^2+x+1.
- R5: Output bit j of a codeword (j=0..14) appears on dout, with dout_valid high, in the clock that follows input clock j. Clock 0 is the clock in which start is accepted. dout_valid is high for exactly 15 clocks per accepted start.
- R6: A start in the clock right after the fifteenth input clock is accepted, and that codeword comes out correct. The parity register starts from zero with no idle cycle in between, and dout_valid stays high across the boundary.
- R7: A start during input clocks 1 to 14 of a codeword is ignored, and the codeword in progress comes out unchanged.
- R8: The value of din during the 15-k parity clocks has no effect on the output.
- R9: A synchronous reset drives dout_valid low in the next clock and abandons any codeword in progress. A codeword started after the reset is correct.
- R10: With no codeword in progress and start low, dout_valid stays low whatever din does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a codeword; din holds the first message bit in the same clock |
| din | input | 1 | Serial message bit, highest degree first |
| dout | output | 1 | Serial codeword bit, registered |
| dout_valid | output | 1 | High while dout carries a codeword bit |

## Verification
On every clock the assertions check that an accepted start makes dout_valid rise one clock later, that an idle clock without start keeps it low, that reset clears it, and that each message-phase bit reappears on dout one clock after it came in. Parity values cannot be shown this way. The bench's scenarios compare whole codewords against a software long-division model: every message of each of the three codes sent back to back, a start strobe in mid-codeword, junk din during the parity clocks, idle gaps with a toggling din, and a reset during a codeword.

// File: rtl/bch15_pkg.sv
package bch15_pkg;
  localparam int CW_LEN = 15;

  // message length for a given error-correcting capability
  function automatic int msg_len(input int t);
    case (t)
      1: msg_len = 11;
      3: msg_len = 5;
      default: msg_len = 7;
    endcase
  endfunction

  // generator polynomial without its leading term, bit i = coefficient of x^i
  function automatic logic [9:0] gen_low(input int t);
    case (t)
      1: gen_low = 10'h003;
      3: gen_low = 10'h137;
      default: gen_low = 10'h0D1;
    endcase
  endfunction
endpackage

// File: rtl/bch15_seq.sv
module bch15_seq #(
  parameter int N  = 15,
  parameter int K  = 7,
  parameter int PW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic live,
  output logic msg_phase
);
  localparam logic [PW-1:0] LAST = PW'(N - 1);
  localparam logic [PW-1:0] KPOS = PW'(K);

  logic          busy_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] cur_pos;

  assign accept    = start & ~busy_q;
  assign live      = accept | busy_q;
  assign cur_pos   = accept ? '0 : pos_q;
  assign msg_phase = live & (cur_pos < KPOS);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (live) begin
      if (cur_pos == LAST) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
      end else begin
        busy_q <= 1'b1;
        pos_q  <= cur_pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bch15_divider.sv
module bch15_divider #(
  parameter int R = 8,
  parameter logic [R-1:0] GLOW = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic live,
  input  logic msg_phase,
  input  logic din,
  output logic par_bit
);
  logic [R-1:0] rem_q;
  logic [R-1:0] base;
  logic [R-1:0] shifted;
  logic [R-1:0] rem_d;
  logic         fb;

  assign base    = clear ? '0 : rem_q;
  assign shifted = {base[R-2:0], 1'b0};
  assign fb      = din ^ base[R-1];
  assign par_bit = base[R-1];

  always_comb begin
    if (msg_phase && fb) rem_d = shifted ^ GLOW;
    else                 rem_d = shifted;
  end

  always_ff @(posedge clk) begin
    if (rst)       rem_q <= '0;
    else if (live) rem_q <= rem_d;
  end
endmodule

// File: rtl/bch15_outreg.sv
module bch15_outreg (
  input  logic clk,
  input  logic rst,
  input  logic live,
  input  logic msg_phase,
  input  logic din,
  input  logic par_bit,
  output logic dout,
  output logic dout_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= 1'b0;
      dout_valid <= 1'b0;
    end else begin
      dout       <= live & (msg_phase ? din : par_bit);
      dout_valid <= live;
    end
  end
endmodule

// File: rtl/bch15_enc.sv
module bch15_enc #(
  parameter int T_CORR = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic din,
  output logic dout,
  output logic dout_valid
);
  localparam int N  = bch15_pkg::CW_LEN;
  localparam int K  = bch15_pkg::msg_len(T_CORR);
  localparam int R  = N - K;
  localparam int PW = $clog2(N);
  localparam logic [R-1:0] GLOW = R'(bch15_pkg::gen_low(T_CORR));

  logic accept, live, msg_phase, par_bit;

  bch15_seq #(.N(N), .K(K), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .accept(accept), .live(live), .msg_phase(msg_phase)
  );

  bch15_divider #(.R(R), .GLOW(GLOW)) u_div (
    .clk(clk), .rst(rst), .clear(accept), .live(live),
    .msg_phase(msg_phase), .din(din), .par_bit(par_bit)
  );

  bch15_outreg u_out (
    .clk(clk), .rst(rst), .live(live), .msg_phase(msg_phase),
    .din(din), .par_bit(par_bit), .dout(dout), .dout_valid(dout_valid)
  );
endmodule

// File: rtl/bch15_enc_chk.sv
module bch15_enc_chk #(
  parameter int K = 7
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic din,
  input logic dout,
  input logic dout_valid
);
  logic       ck_busy;
  logic [3:0] ck_pos;
  logic       ck_acc;
  logic [3:0] ck_cur;

  assign ck_acc = start && !ck_busy;
  assign ck_cur = ck_acc ? 4'd0 : ck_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_busy <= 1'b0;
      ck_pos  <= 4'd0;
    end else if (ck_acc || ck_busy) begin
      ck_busy <= (ck_cur != 4'd14);
      ck_pos  <= (ck_cur == 4'd14) ? 4'd0 : ck_cur + 4'd1;
    end
  end

  // R5: an accepted start yields a valid output bit next clock
  p_valid_follow_r5: assert property (@(posedge clk) disable iff (rst)
    ck_acc |=> dout_valid);

  // R10: idle without start keeps valid low
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!start && !ck_busy) |=> !dout_valid);

  // R1: message bits pass through one clock later
  p_passthru_r1: assert property (@(posedge clk) disable iff (rst)
    ((ck_acc || ck_busy) && (ck_cur < 4'(K))) |=> (dout == $past(din)));

  // R9: reset clears valid in the next clock
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> !dout_valid);
endmodule

bind bch15_enc bch15_enc_chk #(.K(K)) u_chk (
  .clk(clk), .rst(rst), .start(start), .din(din),
  .dout(dout), .dout_valid(dout_valid)
);

// File: tb/sim_bch15_enc.sv
`timescale 1ns/1ps
module sim_bch15_enc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] start_v = '0;
  logic [2:0] din_v = '0;
  logic [2:0] dout_v, valid_v;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  // slot 0: T=2 (default), slot 1: T=1, slot 2: T=3
  bch15_enc u0 (.clk(clk), .rst(rst), .start(start_v[0]), .din(din_v[0]),
                .dout(dout_v[0]), .dout_valid(valid_v[0]));
  bch15_enc #(.T_CORR(1)) u1 (.clk(clk), .rst(rst), .start(start_v[1]), .din(din_v[1]),
                .dout(dout_v[1]), .dout_valid(valid_v[1]));
  bch15_enc #(.T_CORR(3)) u3 (.clk(clk), .rst(rst), .start(start_v[2]), .din(din_v[2]),
                .dout(dout_v[2]), .dout_valid(valid_v[2]));

  function automatic int tcorr(input int c);
    tcorr = (c == 0) ? 2 : (c == 1) ? 1 : 3;
  endfunction
  function automatic int kof(input int c);
    kof = (c == 0) ? 7 : (c == 1) ? 11 : 5;
  endfunction
  function automatic logic [14:0] gfull(input int t);
    gfull = (t == 1) ? 15'h0013 : (t == 3) ? 15'h0537 : 15'h01D1;
  endfunction

  // software long-division model of the codeword, bit 14 sent first
  function automatic logic [14:0] model(input int c, input int m);
    int k, r;
    logic [14:0] sys, w, g;
    k = kof(c); r = 15 - k; g = gfull(tcorr(c));
    sys = 15'(m) << r;
    w = sys;
    for (int i = 14; i >= r; i--)
      if (w[i]) w = w ^ (g << (i - r));
    model = sys | w;
  endfunction

  // collector: packs valid output bits into words
  logic [14:0] got [3][2048];
  logic [14:0] sh [3];
  int nbit [3];
  int nword [3];
  int gaps [3];
  initial for (int c = 0; c < 3; c++) begin sh[c] = '0; nbit[c] = 0; nword[c] = 0; gaps[c] = 0; end

  always @(negedge clk) begin
    for (int c = 0; c < 3; c++) begin
      if (rst) nbit[c] = 0;
      else if (valid_v[c]) begin
        sh[c] = {sh[c][13:0], dout_v[c]};
        nbit[c] = nbit[c] + 1;
        if (nbit[c] == 15) begin
          if (nword[c] < 2048) got[c][nword[c]] = sh[c];
          nword[c] = nword[c] + 1;
          nbit[c] = 0;
        end
      end else if (nbit[c] != 0) gaps[c] = gaps[c] + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int c, input int m, input bit mid_start, input bit junk);
    int k = kof(c);
    for (int j = 0; j < 15; j++) begin
      @(negedge clk);
      start_v[c] = (j == 0) || (mid_start && (j == 5 || j == 14));
      din_v[c] = (j < k) ? m[k-1-j] : (junk ^ j[0]);
    end
  endtask

  task automatic idle(input int c, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      start_v[c] = 1'b0;
      din_v[c] = j[0];
    end
  endtask

  task automatic t_reset_state;
    check("R9 reset valid", {29'd0, valid_v}, 32'd0);
    check("R9 reset dout", {29'd0, dout_v}, 32'd0);
  endtask

  // R1 R2 R3 R4 R5 R6: every message, back to back
  task automatic t_exhaustive(input int c, input string req);
    int w0 = nword[c];
    int cnt = 1 << kof(c);
    for (int m = 0; m < cnt; m++) send(c, m, 1'b0, 1'b0);
    idle(c, 4);
    check({req, " R5 word count"}, 32'(nword[c] - w0), 32'(cnt));
    check("R5 partial bits", 32'(nbit[c]), 32'd0);
    check("R6 no valid gap", 32'(gaps[c]), 32'd0);
    for (int m = 0; m < cnt; m++)
      check({req, " R1 codeword"}, {17'd0, got[c][w0+m]}, {17'd0, model(c, m)});
  endtask

  // R7: stray starts inside a codeword
  task automatic t_mid_start;
    int w0 = nword[0];
    send(0, 7'h59, 1'b1, 1'b0);
    idle(0, 4);
    check("R7 one word", 32'(nword[0] - w0), 32'd1);
    check("R7 codeword", {17'd0, got[0][w0]}, {17'd0, model(0, 7'h59)});
  endtask

  // R8: junk din during parity clocks
  task automatic t_parity_din;
    int w0 = nword[2];
    send(2, 5'h06, 1'b0, 1'b1);
    send(2, 5'h1B, 1'b0, 1'b0);
    idle(2, 4);
    check("R8 word a", {17'd0, got[2][w0]}, {17'd0, model(2, 5'h06)});
    check("R8 word b", {17'd0, got[2][w0+1]}, {17'd0, model(2, 5'h1B)});
  endtask

  // R10: toggling din without start
  task automatic t_idle;
    int w0 = nword[0];
    idle(0, 20);
    check("R10 no words", 32'(nword[0] - w0), 32'd0);
    check("R10 no bits", 32'(nbit[0]), 32'd0);
    check("R10 valid low", {31'd0, valid_v[0]}, 32'd0);
  endtask

  // R9: reset in mid-codeword
  task automatic t_reset_mid;
    int w0 = nword[0];
    for (int j = 0; j < 6; j++) begin
      @(negedge clk); start_v[0] = (j == 0); din_v[0] = 1'b1;
    end
    @(negedge clk); start_v[0] = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 valid after reset", {31'd0, valid_v[0]}, 32'd0);
    send(0, 7'h2A, 1'b0, 1'b0);
    idle(0, 4);
    check("R9 words after reset", 32'(nword[0] - w0), 32'd1);
    check("R9 codeword after reset", {17'd0, got[0][w0]}, {17'd0, model(0, 7'h2A)});
  endtask

  initial begin
    #700000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_exhaustive(0, "R3");
    t_exhaustive(1, "R2");
    t_exhaustive(2, "R4");
    t_mid_start();
    t_parity_din();
    t_idle();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule